// File: doc/BRIEF.md
# Protected Power-of-Two Clock Divider

This block derives a system clock from a fast source clock by dividing it by 2^n, where n is a small code held in the block. The code can only be altered by a two-write handshake: a key write opens a short window, and a second write inside that window carries the new code. Stray writes, late writes and malformed keys leave the setting as it was. The divisor counter always runs on the source clock.

The output is built from a source-clock register and a gate against the source clock's low phase. One pulse of half a source period appears once per divided period. A one-cycle strobe `sys_tick` marks the source cycle that holds that pulse, so that synchronous logic on the source clock can use it as a clock enable. The register interface itself samples only on source edges that close a strobe cycle, and its window is counted in those strobes. A new code is loaded only at the moment the counter wraps. The interval that starts at the accepting edge therefore keeps the old length, and every interval after it has the new length. No interval is shorter than both.

Top module: `clkdiv_prescaler`

## Requirements
- R1: While `rst_n` is low, on every source edge the code returns to 0 (divide by 1), any open unlock window is closed, `sys_tick` stays high and `sys_clk` keeps running as the inverted source clock.
- R2: The control word is 8 bits. Bit 7 is the change-enable flag and bits 3:0 carry the code. Bits 6:4 are ignored in a code write. Only the exact value 0x80 opens the unlock window.
- R3: With code c in 0..8, `sys_tick` is high for one source cycle in every 2^c. `sys_clk` is high only in the low half of those cycles and is low at all other times.
- R4: A write with bit 7 clear takes effect only when it is accepted on one of the first four strobe edges after the key write. On the fifth such edge or later it is ignored.
- R5: A write with bit 7 clear and no open window leaves the code unchanged.
- R6: A code from 9 to 15 written inside the window leaves the code unchanged and closes the window.
- R7: Inside the window, a write with bit 7 set other than 0x80 closes the window. A repeated 0x80 restarts the four-strobe count.
- R8: After an accepted code change, the strobe interval that begins at the accepting edge has the old length 2^old. Every later interval has the length 2^new.
- R9: Writes are sampled only on source edges that end a `sys_tick` cycle. A write held during other cycles neither applies a code nor uses up a window strobe.
- R10: `clk_out_tap` follows `sys_clk` at all times, reset included.
- R11: `div_sel` shows the new code from the accepting edge onward. A successful code write closes the window, so a further code write needs a new key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write request, sampled on strobe edges |
| wr_data | input | 8 | Control write value |
| sys_clk | output | 1 | Divided, gated system clock |
| sys_tick | output | 1 | High for the source cycle holding a system clock pulse |
| clk_out_tap | output | 1 | Copy of the divided clock for an output pin |
| div_sel | output | 4 | Code currently in effect |

## Verification
Every pair of old and new codes from 0 to 6 is switched, plus the extreme 0-to-8, 8-to-0 and 8-to-3 switches. The three intervals after each switch are measured against 2^old and 2^new, which tells a correct wrap-time load apart from an early or late one. Window tests place the code write on the fourth and the fifth strobe, after a restarted key, after a cancelling key and after a reserved code, which separates off-by-one window counts from missing cancel paths. A write held only through non-strobe cycles, followed by an in-window write, checks both that writes are sampled only on strobe edges and that such a held write uses up no window strobe.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and types of the protected clock divider.
// Assumes: all users take their default widths from here.
package clkdiv_pkg;
    localparam int CTRL_W    = 8;   // control word width
    localparam int SEL_W     = 4;   // code field width
    localparam int MAX_SEL   = 8;   // highest legal code (divide by 256)
    localparam int CE_BIT    = 7;   // change-enable flag position
    localparam int WIN_TICKS = 4;   // strobes allowed after the key

    typedef enum logic [0:0] {
        ULK_SHUT = 1'b0,
        ULK_OPEN = 1'b1
    } ulk_state_e;
endpackage

// File: rtl/clkdiv_unlock.sv
// Module: two-step guarded write sequencer.
// Does: accepts the key word, keeps a strobe-counted window open and emits a
//       one-cycle update request with the new code when a legal code arrives.
// Assumes: tick is high for exactly the source cycles that end a divided period.
module clkdiv_unlock
    import clkdiv_pkg::*;
#(
    parameter int CW    = CTRL_W,
    parameter int SW    = SEL_W,
    parameter int MS    = MAX_SEL,
    parameter int CEB   = CE_BIT,
    parameter int WIN   = WIN_TICKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic          upd_en,
    output logic [SW-1:0] upd_sel
);
    localparam int WW = $clog2(WIN + 1);
    localparam logic [CW-1:0] KEY = CW'(1) << CEB;

    ulk_state_e    state_q, state_n;
    logic [WW-1:0] win_q, win_n;
    logic          take, is_key, legal;

    // Decode the sampled write.
    always_comb begin
        take    = wr_en && tick;
        is_key  = (wr_data == KEY);
        legal   = (int'(wr_data[SW-1:0]) <= MS);
        upd_sel = wr_data[SW-1:0];
    end

    // Next-state logic of the window sequencer.
    always_comb begin
        state_n = state_q;
        win_n   = win_q;
        upd_en  = 1'b0;
        if (tick) begin
            unique case (state_q)
                ULK_SHUT: begin
                    if (take && is_key) begin
                        state_n = ULK_OPEN;
                        win_n   = WW'(WIN);
                    end
                end
                ULK_OPEN: begin
                    if (take) begin
                        if (is_key) begin
                            win_n = WW'(WIN);
                        end else begin
                            state_n = ULK_SHUT;
                            win_n   = '0;
                            upd_en  = !wr_data[CEB] && legal;
                        end
                    end else if (win_q <= WW'(1)) begin
                        state_n = ULK_SHUT;
                        win_n   = '0;
                    end else begin
                        win_n = win_q - WW'(1);
                    end
                end
                default: begin
                    state_n = ULK_SHUT;
                    win_n   = '0;
                end
            endcase
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ULK_SHUT;
            win_q   <= '0;
        end else begin
            state_q <= state_n;
            win_q   <= win_n;
        end
    end
endmodule

// File: rtl/clkdiv_counter.sv
// Module: divisor counter and active code register.
// Does: counts down on the source clock, reloads 2^code-1 at each wrap and
//       flags the wrap cycle with a registered strobe; a new code is taken
//       only at a wrap edge so the current interval always finishes.
// Assumes: upd_en is only ever high while tick_q is high.
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int MS = MAX_SEL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    output logic [SW-1:0] sel_q,
    output logic          tick_q
);
    localparam int CNT_W = (MS < 1) ? 1 : MS;

    logic [CNT_W-1:0] cnt_q, cnt_n, reload;

    // Reload value: ones in the low sel_q bits.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            reload[i] = (i < int'(sel_q));
        end
    end

    // Next count: wrap to reload at zero, otherwise count down.
    always_comb begin
        cnt_n = (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);
    end

    // Counter, strobe and code registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
            sel_q  <= '0;
        end else begin
            cnt_q  <= cnt_n;
            tick_q <= (cnt_n == '0);
            if (upd_en) begin
                sel_q <= upd_sel;
            end
        end
    end
endmodule

// File: rtl/clkdiv_clkgate.sv
// Module: output clock former.
// Does: passes the source low phase while the registered enable is high,
//       giving one clean pulse per divided period, and optionally copies it
//       to a pin tap.
// Assumes: en_q changes only just after a source rising edge, while the
//          source is high, so the gate output cannot glitch.
module clkdiv_clkgate #(
    parameter bit TAP_EN = 1'b1
) (
    input  logic src_clk,
    input  logic en_q,
    output logic clk_o,
    output logic tap_o
);
    // Gate the low half of the source with the enable.
    always_comb begin
        clk_o = ~src_clk & en_q;
    end

    generate
        if (TAP_EN) begin : g_tap
            // Pin tap follows the gated clock.
            always_comb tap_o = clk_o;
        end else begin : g_no_tap
            // Tap unused: held low.
            always_comb tap_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_prescaler.sv
// Module: top of the protected power-of-two clock divider.
// Does: ties the write sequencer, the divisor counter and the output gate
//       together; the strobe doubles as clock enable for the write port.
// Assumes: rst_n is synchronous to src_clk; writes are held until a strobe.
module clkdiv_prescaler
    import clkdiv_pkg::*;
#(
    parameter int CW     = CTRL_W,
    parameter int SW     = SEL_W,
    parameter int MS     = MAX_SEL,
    parameter int CEB    = CE_BIT,
    parameter int WIN    = WIN_TICKS,
    parameter bit TAP_EN = 1'b1
) (
    input  logic          src_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic          sys_clk,
    output logic          sys_tick,
    output logic          clk_out_tap,
    output logic [SW-1:0] div_sel
);
    logic          upd_en;
    logic [SW-1:0] upd_sel;
    logic          tick_q;

    clkdiv_unlock #(
        .CW (CW), .SW (SW), .MS (MS), .CEB (CEB), .WIN (WIN)
    ) u_unlock (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .tick    (tick_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_sel (upd_sel)
    );

    clkdiv_counter #(
        .SW (SW), .MS (MS)
    ) u_counter (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_sel (upd_sel),
        .sel_q   (div_sel),
        .tick_q  (tick_q)
    );

    clkdiv_clkgate #(
        .TAP_EN (TAP_EN)
    ) u_gate (
        .src_clk (src_clk),
        .en_q    (tick_q),
        .clk_o   (sys_clk),
        .tap_o   (clk_out_tap)
    );

    // Strobe exported for synchronous logic on the source clock.
    always_comb sys_tick = tick_q;
endmodule

// File: rtl/clkdiv_prescaler_chk.sv
// Module: property checker for clkdiv_prescaler, attached by bind.
// Does: measures strobe intervals and key age with its own counters and
//       checks them against the port behaviour.
// Assumes: sampled on the source rising edge, reset synchronous.
module clkdiv_prescaler_chk #(
    parameter int CW  = 8,
    parameter int SW  = 4,
    parameter int MS  = 8,
    parameter int CEB = 7,
    parameter int WIN = 4
) (
    input logic          src_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [CW-1:0] wr_data,
    input logic          sys_tick,
    input logic [SW-1:0] div_sel
);
    localparam int LEN_W = MS + 2;
    localparam int AGE_W = $clog2(WIN + 1);
    localparam logic [CW-1:0] KEY = CW'(1) << CEB;

    logic [LEN_W-1:0] gap_q, exp_len_q;
    logic [AGE_W-1:0] age_q;

    // Interval length since the last strobe and its expected value.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            gap_q     <= LEN_W'(1);
            exp_len_q <= LEN_W'(1);
        end else if (sys_tick) begin
            gap_q     <= LEN_W'(1);
            exp_len_q <= LEN_W'(1) << div_sel;
        end else begin
            gap_q <= gap_q + LEN_W'(1);
        end
    end

    // Strobes elapsed since the last accepted key write, saturating.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            age_q <= AGE_W'(WIN);
        end else if (sys_tick) begin
            if (wr_en && wr_data == KEY) begin
                age_q <= '0;
            end else if (age_q < AGE_W'(WIN)) begin
                age_q <= age_q + AGE_W'(1);
            end
        end
    end

    assert_period_exact_R8: assert property (@(posedge src_clk) disable iff (!rst_n)
        sys_tick |-> gap_q == exp_len_q);

    assert_sel_legal_R6: assert property (@(posedge src_clk) disable iff (!rst_n)
        int'(div_sel) <= MS);

    assert_change_on_write_R9: assert property (@(posedge src_clk) disable iff (!rst_n)
        !$stable(div_sel) |-> ($past(wr_en && sys_tick && !wr_data[CEB])
                               && div_sel == $past(wr_data[SW-1:0])));

    assert_unlock_recent_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
        !$stable(div_sel) |-> $past(age_q) < AGE_W'(WIN));
endmodule

bind clkdiv_prescaler clkdiv_prescaler_chk #(
    .CW (CW), .SW (SW), .MS (MS), .CEB (CEB), .WIN (WIN)
) u_chk (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sys_tick (sys_tick),
    .div_sel  (div_sel)
);

// File: tb/tb_clkdiv_prescaler.sv
`timescale 1ns/1ps
module tb_clkdiv_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sys_clk, sys_tick, clk_out_tap;
    logic [3:0] div_sel;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_prescaler dut (
        .src_clk     (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .sys_clk     (sys_clk),
        .sys_tick    (sys_tick),
        .clk_out_tap (clk_out_tap),
        .div_sel     (div_sel)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_tick();
        while (!sys_tick) step();
    endtask

    // Present a write in a strobe cycle so the closing edge samples it.
    task automatic do_write(logic [7:0] d);
        wait_tick();
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic skip_ticks(int n);
        for (int i = 0; i < n; i++) begin
            wait_tick();
            step();
        end
    endtask

    task automatic set_code(logic [7:0] c);
        do_write(8'h80);
        do_write(c);
    endtask

    // Cycles to the next strobe; from_tick means the caller sits in one.
    task automatic get_gap(bit from_tick, output int g);
        g = 1;
        if (from_tick) step();
        while (!sys_tick) begin
            step();
            g++;
        end
    endtask

    // Check clock levels in a strobe cycle and three intervals of 2^c.
    task automatic measure(int c, string req);
        int g;
        wait_tick();
        check_eq("R3", "sys_clk low in high source phase", int'(sys_clk), 0);
        #2;
        check_eq("R3", "sys_clk pulse in low source phase", int'(sys_clk), 1);
        check_eq("R10", "tap follows divided clock", int'(clk_out_tap), int'(sys_clk));
        step();
        get_gap(1'b0, g);
        check_eq(req, "interval", g, 1 << c);
        for (int i = 0; i < 2; i++) begin
            get_gap(1'b1, g);
            check_eq(req, "interval", g, 1 << c);
        end
    endtask

    // Switch old->new and check the intervals around the switch.
    task automatic switch_pair(int o, int n);
        int g;
        set_code(8'(o));
        set_code(8'(n));
        check_eq("R11", "code visible at accepting edge", int'(div_sel), n);
        get_gap(1'b0, g);
        check_eq("R8", $sformatf("first interval %0d->%0d", o, n), g, 1 << o);
        get_gap(1'b1, g);
        check_eq("R8", $sformatf("second interval %0d->%0d", o, n), g, 1 << n);
        get_gap(1'b1, g);
        check_eq("R8", $sformatf("third interval %0d->%0d", o, n), g, 1 << n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 and R10: reset state, clock alive during reset, key write ignored.
        #1;
        wr_en = 1'b1;
        wr_data = 8'h80;
        repeat (4) step();
        check_eq("R1", "tick during reset", int'(sys_tick), 1);
        check_eq("R1", "code during reset", int'(div_sel), 0);
        check_eq("R1", "sys_clk low while source high", int'(sys_clk), 0);
        #2;
        check_eq("R1", "sys_clk high while source low", int'(sys_clk), 1);
        check_eq("R10", "tap active in reset", int'(clk_out_tap), 1);
        step();
        wr_en = 1'b0;
        wr_data = 8'h00;
        rst_n = 1'b1;
        step();
        do_write(8'h03);
        check_eq("R1", "reset leaves no open window", int'(div_sel), 0);
        measure(0, "R3");

        // R3: every legal code divides by its power of two.
        for (int c = 0; c <= 8; c++) begin
            set_code(8'(c));
            check_eq("R3", "code applied", int'(div_sel), c);
            measure(c, "R3");
        end

        // R8: near-exhaustive switch sweep plus extreme switches.
        for (int o = 0; o <= 6; o++) begin
            for (int n = 0; n <= 6; n++) begin
                switch_pair(o, n);
            end
        end
        switch_pair(0, 8);
        switch_pair(8, 0);
        switch_pair(8, 3);

        // R5: code write with no key is ignored.
        set_code(8'h02);
        do_write(8'h05);
        check_eq("R5", "write without key", int'(div_sel), 2);
        measure(2, "R5");

        // R11: a second code write after a success needs a new key.
        set_code(8'h01);
        do_write(8'h04);
        check_eq("R11", "window closed by success", int'(div_sel), 1);

        // R4: fourth strobe accepted, fifth ignored.
        do_write(8'h80);
        skip_ticks(3);
        do_write(8'h02);
        check_eq("R4", "write on fourth strobe", int'(div_sel), 2);
        do_write(8'h80);
        skip_ticks(4);
        do_write(8'h03);
        check_eq("R4", "write on fifth strobe", int'(div_sel), 2);
        measure(2, "R4");

        // R6: reserved code ignored and window closed.
        do_write(8'h80);
        do_write(8'h0C);
        check_eq("R6", "reserved code", int'(div_sel), 2);
        do_write(8'h01);
        check_eq("R6", "window closed by reserved code", int'(div_sel), 2);
        set_code(8'h0F);
        check_eq("R6", "highest reserved code", int'(div_sel), 2);

        // R7: malformed key cancels; repeated key restarts the count.
        do_write(8'h80);
        do_write(8'h81);
        do_write(8'h01);
        check_eq("R7", "cancel by malformed key", int'(div_sel), 2);
        do_write(8'h80);
        skip_ticks(3);
        do_write(8'h80);
        skip_ticks(3);
        do_write(8'h05);
        check_eq("R7", "restart by repeated key", int'(div_sel), 5);

        // R2: bits 6:4 ignored in code writes; only 0x80 is a key.
        set_code(8'h31);
        check_eq("R2", "upper bits ignored in code write", int'(div_sel), 1);
        do_write(8'h90);
        do_write(8'h03);
        check_eq("R2", "0x90 is not a key", int'(div_sel), 1);
        do_write(8'hC0);
        do_write(8'h03);
        check_eq("R2", "0xC0 is not a key", int'(div_sel), 1);

        // R9: write held only in non-strobe cycles neither applies nor uses a strobe.
        set_code(8'h03);
        do_write(8'h80);
        wr_data = 8'h01;
        while (!sys_tick) begin
            wr_en = 1'b1;
            step();
        end
        wr_en = 1'b0;
        wr_data = 8'h00;
        check_eq("R9", "write outside strobe ignored", int'(div_sel), 3);
        skip_ticks(2);
        do_write(8'h02);
        check_eq("R9", "window intact after off-strobe write", int'(div_sel), 2);
        measure(2, "R9");

        // R1: reset in operation returns to divide by 1.
        set_code(8'h05);
        #1;
        rst_n = 1'b0;
        step();
        check_eq("R1", "code after reset", int'(div_sel), 0);
        check_eq("R1", "tick after reset", int'(sys_tick), 1);
        step();
        rst_n = 1'b1;
        measure(0, "R1");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule